// File: doc/BRIEF.md
# Pixel Color Matrix Transform

This block applies a 3x3 color matrix, a per-component offset and output limiting to a stream of 24-bit RGB pixels. Every pixel carries a 2-bit tag naming the display channel it belongs to. The block has one transform engine. A channel-select field decides which single channel is transformed. Pixels from every other channel, and all pixels while the select field is zero, leave the block unchanged.

Software writes configuration words into a shadow bank through a plain write port. On each `frame_start` pulse the whole shadow bank is copied into the active bank, so one frame never mixes two coefficient sets. The copy uses the shadow contents from before any write in the same cycle. A pixel takes its configuration from the active bank in the cycle it is accepted.

Both pixel interfaces use valid/ready. A pixel moves on a rising edge where valid and ready are both high. The two pipeline stages stall together. `in_ready` is high when the output register is empty or `out_ready` is high, and it never depends on `in_valid`. While `out_valid` is high and `out_ready` is low, the output tag and pixel are held. Pixels are never dropped, duplicated or reordered.

Top module: `colmat_top`

## Requirements
- R1: After reset, and whenever the select field is 0, every pixel leaves with the same tag and the same RGB value it came in with.
- R2: Each coefficient is 10 bits wide. Bit 9 is the sign and bits 8:0 are the magnitude in units of 1/512. A coefficient word carries the terms from one source component: the destination R term in bits 29:20, G in 19:10 and B in 9:0. The red source is at address 0x8C, green at 0x88 and blue at 0x84. A destination value is the full-precision sum of the three source components, each multiplied by its signed coefficient. Pixel bits 23:16 are R, 15:8 are G and 7:0 are B.
- R3: The sum, in units of 1/512, is rounded to the nearest integer, with exact halves rounded toward positive infinity. The offset is added after this rounding.
- R4: The control word at address 0x80 holds three 8-bit two's-complement offsets, which are added to the rounded sums: R in bits 23:16, G in 15:8 and B in 7:0.
- R5: The result saturates to the range 0..255.
- R6: When bit 31 of the control word is set, the saturated result is limited further: R to 16..235, and G and B to 16..240.
- R7: Control bits 25:24 select the transformed channel. Code 1 selects tag 0, code 2 selects tag 1 and code 3 selects tag 2. Pixels with any other tag, including tag 3, pass through unchanged.
- R8: Writes reach the active configuration only at a `frame_start` pulse. A write made in the same cycle as the pulse waits for the next pulse.
- R9: When `out_ready` stays high, an accepted pixel appears with `out_valid` high at the second rising edge after its acceptance.
- R10: While `out_valid` is high and `out_ready` is low, the output is held and `in_ready` is low. All pixels leave in the order they arrived.
- R11: Writes to any address other than 0x80, 0x84, 0x88 and 0x8C change nothing.
- R12: During reset and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Pulse that copies the shadow bank into the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_chan | input | 2 | Input channel tag |
| in_rgb | input | 24 | Input pixel, with R in the top byte |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_chan | output | 2 | Output channel tag |
| out_rgb | output | 24 | Output pixel, with R in the top byte |

## Verification
The hardest cases to reach are a pending configuration that must not take effect yet, and a write that lands in the same cycle as the frame pulse. Both are only visible through the pixel values that come out later. The stimulus therefore writes a new offset with no pulse, sends a pixel whose result would differ under that offset, and then issues a combined write and pulse to show that the older shadow value is the one that becomes active. The rounding boundaries are reached with single-bit pixel values and coefficients of exactly one half, just under one half and just over minus one half. Random back-pressure on `out_ready` during a burst of tagged pixels exercises the hold and ordering rules.

// File: rtl/colmat_pkg.sv
package colmat_pkg;
  localparam int PIX_W  = 8;
  localparam int MAG_W  = 9;
  localparam int CF_W   = MAG_W + 1;
  localparam int OFS_W  = 8;
  localparam int NCOMP  = 3;
  localparam int SUM_W  = PIX_W + MAG_W + 3;

  localparam logic [7:0] A_CTRL  = 8'h80;
  localparam logic [7:0] A_SRC_B = 8'h84;
  localparam logic [7:0] A_SRC_G = 8'h88;
  localparam logic [7:0] A_SRC_R = 8'h8C;

  localparam int LIM_LO   = 16;
  localparam int LIM_HI_R = 235;
  localparam int LIM_HI_O = 240;

  // component index: 0 = R, 1 = G, 2 = B
  typedef struct packed {
    logic                                   clamp_en;
    logic [1:0]                             sel;
    logic [NCOMP-1:0][OFS_W-1:0]            ofs;
    logic [NCOMP-1:0][NCOMP-1:0][CF_W-1:0]  k;   // k[src][dst]
  } cfg_t;

  function automatic logic [7:0] src_addr(input int s);
    if (s == 0)      return A_SRC_R;
    else if (s == 1) return A_SRC_G;
    else             return A_SRC_B;
  endfunction
endpackage

// File: rtl/colmat_regs.sv
module colmat_regs import colmat_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  output cfg_t              active
);
  cfg_t shadow;
  logic unused_bits;
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr_en) begin
        if (wr_addr == ADDR_W'(A_CTRL)) begin
          shadow.clamp_en <= wr_data[31];
          shadow.sel      <= wr_data[25:24];
          for (int c = 0; c < NCOMP; c++)
            shadow.ofs[c] <= wr_data[(NCOMP-1-c)*OFS_W +: OFS_W];
        end
        for (int s = 0; s < NCOMP; s++) begin
          if (wr_addr == ADDR_W'(src_addr(s))) begin
            for (int d = 0; d < NCOMP; d++)
              shadow.k[s][d] <= wr_data[(NCOMP-1-d)*CF_W +: CF_W];
          end
        end
      end
      // the copy sees the shadow value from before a same-cycle write
      if (frame_start) active <= shadow;
    end
  end
endmodule

// File: rtl/colmat_dot.sv
module colmat_dot #(
  parameter int PIX_W = 8,
  parameter int MAG_W = 9,
  parameter int NCOMP = 3,
  parameter int SUM_W = PIX_W + MAG_W + 3
) (
  input  logic [NCOMP-1:0][PIX_W-1:0]  pix,   // indexed by source
  input  logic [NCOMP-1:0][MAG_W:0]    coef,  // indexed by source
  output logic signed [SUM_W-1:0]      sum
);
  localparam int PW = PIX_W + MAG_W;
  logic signed [SUM_W-1:0] term [NCOMP];

  for (genvar s = 0; s < NCOMP; s++) begin : g_term
    logic [PW-1:0]           mag_p;
    logic signed [SUM_W-1:0] mag_s;
    assign mag_p   = PW'(pix[s]) * PW'(coef[s][MAG_W-1:0]);
    assign mag_s   = $signed(SUM_W'(mag_p));
    assign term[s] = coef[s][MAG_W] ? -mag_s : mag_s;
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < NCOMP; s++) sum = sum + term[s];
  end
endmodule

// File: rtl/colmat_fin.sv
module colmat_fin #(
  parameter int PIX_W = 8,
  parameter int MAG_W = 9,
  parameter int OFS_W = 8,
  parameter int SUM_W = PIX_W + MAG_W + 3
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic [OFS_W-1:0]        ofs,
  input  logic                    clamp_en,
  input  logic [PIX_W-1:0]        lo,
  input  logic [PIX_W-1:0]        hi,
  output logic [PIX_W-1:0]        res
);
  localparam int V_W = SUM_W - MAG_W + 2;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (MAG_W - 1));
  localparam logic signed [V_W-1:0]   VMAX = V_W'((1 << PIX_W) - 1);

  logic signed [V_W-1:0] v;
  logic [PIX_W-1:0]      sat;

  assign v = V_W'((sum + HALF) >>> MAG_W) + V_W'($signed(ofs));

  always_comb begin
    if (v < 0)          sat = '0;
    else if (v > VMAX)  sat = '1;
    else                sat = v[PIX_W-1:0];
    res = sat;
    if (clamp_en) begin
      if (sat < lo)      res = lo;
      else if (sat > hi) res = hi;
    end
  end
endmodule

// File: rtl/colmat_top.sv
module colmat_top import colmat_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     frame_start,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CH_W-1:0]          in_chan,
  input  logic [NCOMP*PIX_W-1:0]   in_rgb,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CH_W-1:0]          out_chan,
  output logic [NCOMP*PIX_W-1:0]   out_rgb
);
  cfg_t act_cfg;
  logic advance;
  logic hit;

  logic [NCOMP-1:0][PIX_W-1:0] pix_arr;   // [NCOMP-1] is R
  logic [NCOMP-1:0][PIX_W-1:0] pix_src;   // [0] is R
  logic signed [SUM_W-1:0]     dot_sum [NCOMP];

  logic                        s1_valid;
  logic [CH_W-1:0]             s1_chan;
  logic [NCOMP*PIX_W-1:0]      s1_rgb;
  logic                        s1_hit;
  logic                        s1_clamp;
  logic [NCOMP-1:0][OFS_W-1:0] s1_ofs;
  logic signed [SUM_W-1:0]     s1_sum [NCOMP];

  logic [NCOMP-1:0][PIX_W-1:0] mat_arr;   // [NCOMP-1] is R

  colmat_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .frame_start(frame_start), .active(act_cfg)
  );

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign pix_arr  = in_rgb;
  assign hit      = (act_cfg.sel != 2'd0) &&
                    (in_chan == (CH_W'(act_cfg.sel) - CH_W'(1)));

  for (genvar d = 0; d < NCOMP; d++) begin : g_comp
    logic [NCOMP-1:0][CF_W-1:0] kcol;
    logic [PIX_W-1:0]           px;
    assign pix_src[d] = pix_arr[NCOMP-1-d];
    for (genvar s = 0; s < NCOMP; s++) begin : g_src
      assign kcol[s] = act_cfg.k[s][d];
    end

    colmat_dot #(.PIX_W(PIX_W), .MAG_W(MAG_W), .NCOMP(NCOMP), .SUM_W(SUM_W)) u_dot (
      .pix(pix_src), .coef(kcol), .sum(dot_sum[d])
    );

    colmat_fin #(.PIX_W(PIX_W), .MAG_W(MAG_W), .OFS_W(OFS_W), .SUM_W(SUM_W)) u_fin (
      .sum(s1_sum[d]), .ofs(s1_ofs[d]), .clamp_en(s1_clamp),
      .lo(PIX_W'(LIM_LO)), .hi((d == 0) ? PIX_W'(LIM_HI_R) : PIX_W'(LIM_HI_O)),
      .res(px)
    );
    assign mat_arr[NCOMP-1-d] = px;
  end

  // stage 1: products summed, configuration snapshot taken with the pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_rgb   <= '0;
      s1_hit   <= 1'b0;
      s1_clamp <= 1'b0;
      s1_ofs   <= '0;
      for (int d = 0; d < NCOMP; d++) s1_sum[d] <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_chan  <= in_chan;
      s1_rgb   <= in_rgb;
      s1_hit   <= hit;
      s1_clamp <= act_cfg.clamp_en;
      s1_ofs   <= act_cfg.ofs;
      for (int d = 0; d < NCOMP; d++) s1_sum[d] <= dot_sum[d];
    end
  end

  // stage 2: round, offset, limit, pick bypass or transformed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_rgb   <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      out_chan  <= s1_chan;
      out_rgb   <= s1_hit ? mat_arr : s1_rgb;
    end
  end
endmodule

// File: rtl/colmat_chk.sv
module colmat_chk import colmat_pkg::*; #(
  parameter int CH_W  = 2,
  parameter int RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CH_W-1:0]  out_chan,
  input logic [RGB_W-1:0] out_rgb,
  input logic             frame_start,
  input cfg_t             shd_cfg,
  input cfg_t             act_cfg
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_chan)));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_cfg == $past(shd_cfg)));
endmodule

bind colmat_top colmat_chk #(.CH_W(CH_W), .RGB_W(NCOMP*PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
  .out_rgb(out_rgb), .frame_start(frame_start),
  .shd_cfg(u_regs.shadow), .act_cfg(act_cfg)
);

// File: tb/colmat_top_bench.sv
`timescale 1ns/1ps
module colmat_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_chan = '0;
  logic [23:0] in_rgb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_chan;
  logic [23:0] out_rgb;

  always #2 clk = ~clk;

  colmat_top u_colmat_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_chan(in_chan), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_rgb(out_rgb)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit bp_on = 0;
  logic [31:0] sh_ctrl = '0, act_ctrl = '0;
  logic [31:0] sh_k [3];
  logic [31:0] act_k [3];
  logic [25:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [9:0] enc(input int v);
    if (v < 0) return {1'b1, 9'(-v)};
    return {1'b0, 9'(v)};
  endfunction

  // terms toward R, G, B destinations
  function automatic logic [31:0] cw(input int to_r, input int to_g, input int to_b);
    return {2'b00, enc(to_r), enc(to_g), enc(to_b)};
  endfunction

  function automatic logic [31:0] ctl(input bit clamp, input int sel, input int orr, input int og, input int ob);
    return {clamp, 5'b0, 2'(sel), 8'(orr), 8'(og), 8'(ob)};
  endfunction

  function automatic logic [23:0] model(input logic [1:0] ch, input logic [23:0] rgb);
    logic [1:0]  sel;
    logic [23:0] r;
    sel = act_ctrl[25:24];
    if (sel == 2'd0 || ch != sel - 2'd1) return rgb;
    r = '0;
    for (int d = 0; d < 3; d++) begin
      int acc;
      int v;
      int hi;
      logic [9:0] f;
      acc = 0;
      for (int s = 0; s < 3; s++) begin
        f = act_k[s][(2-d)*10 +: 10];
        acc += (f[9] ? -1 : 1) * int'(f[8:0]) * int'(rgb[(2-s)*8 +: 8]);
      end
      v = ((acc + 256) >>> 9) + int'($signed(act_ctrl[(2-d)*8 +: 8]));
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      hi = (d == 0) ? 235 : 240;
      if (act_ctrl[31]) begin
        if (v < 16) v = 16;
        if (v > hi) v = hi;
      end
      r[(2-d)*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic void shadow_update(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h80: sh_ctrl  = d;
      8'h8C: sh_k[0]  = d;
      8'h88: sh_k[1]  = d;
      8'h84: sh_k[2]  = d;
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    shadow_update(a, d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1;
    act_ctrl = sh_ctrl;
    for (int i = 0; i < 3; i++) act_k[i] = sh_k[i];
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; frame_start = 1;
    act_ctrl = sh_ctrl;
    for (int i = 0; i < 3; i++) act_k[i] = sh_k[i];
    shadow_update(a, d);
    @(negedge clk);
    cfg_we = 0; frame_start = 0;
  endtask

  task automatic send(input logic [1:0] ch, input logic [23:0] rgb, input string tag);
    @(negedge clk);
    in_valid = 1; in_chan = ch; in_rgb = rgb;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back({ch, model(ch, rgb)});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain(input string tag);
    bp_on = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      #2;
      if (exp_q.size() == 0) break;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  always @(negedge clk) out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;

  // monitor: pops expected pixels as the design delivers them
  initial begin
    logic        stalled;
    logic [25:0] held;
    logic [25:0] e;
    string       t;
    stalled = 0;
    held = '0;
    forever begin
      @(negedge clk);
      #1;
      if (stalled)
        check(out_valid && ({out_chan, out_rgb} == held), "R10 hold under stall",
              {5'b0, out_valid, out_chan, out_rgb}, {6'b1, held});
      stalled = out_valid && !out_ready;
      held = {out_chan, out_rgb};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R10 unexpected output", {6'b0, out_chan, out_rgb}, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_chan, out_rgb} == e, t, {6'b0, out_chan, out_rgb}, {6'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin sh_k[i] = '0; act_k[i] = '0; end
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 0, "R12 out_valid in reset", out_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(out_valid == 0, "R12 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R12 in_ready after reset", in_ready, 1);

    // R1: defaults pass everything through
    send(2'd0, 24'h123456, "R1 pass tag0");
    send(2'd1, 24'hFF0080, "R1 pass tag1");
    send(2'd2, 24'h00FFFF, "R1 pass tag2");
    send(2'd3, 24'hA5A5A5, "R1 pass tag3");
    drain("R1 drain");

    // R9: two-edge latency
    send(2'd0, 24'h010203, "R9 latency pixel");
    @(negedge clk); #1;
    check(out_valid == 0, "R9 not after one edge", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1, "R9 valid after two edges", out_valid, 1);
    drain("R9 drain");

    // R8: pending writes have no effect until the frame pulse
    wr(8'h8C, cw(511, 0, 0));
    wr(8'h88, cw(0, 511, 0));
    wr(8'h84, cw(0, 0, 511));
    wr(8'h80, ctl(0, 1, 10, 10, 10));
    send(2'd0, 24'h804020, "R8 no pulse yet");
    frame();
    send(2'd0, 24'h804020, "R8 after pulse");
    wr_frame(8'h80, ctl(0, 1, -20, -20, -20));
    send(2'd0, 24'h804020, "R8 same-cycle write waits");
    frame();
    send(2'd0, 24'h804020, "R8 second pulse");
    drain("R8 drain");

    // R2: packing and signed coefficients
    wr(8'h8C, cw(0, 511, 0));
    wr(8'h88, cw(0, 0, 511));
    wr(8'h84, cw(511, 0, 0));
    wr(8'h80, ctl(0, 1, 0, 0, 0));
    frame();
    send(2'd0, 24'h804020, "R2 rotated matrix");
    send(2'd0, 24'hFF0010, "R2 rotated matrix b");
    wr(8'h8C, cw(256, -128, 100));
    wr(8'h88, cw(-300, 200, 50));
    wr(8'h84, cw(50, -50, 400));
    wr(8'h80, ctl(0, 1, 3, -7, 12));
    frame();
    send(2'd0, 24'hC86432, "R2 mixed signs");
    send(2'd0, 24'h10F0A0, "R2 mixed signs b");

    // R3: rounding boundaries
    wr(8'h8C, cw(256, 255, -257));
    wr(8'h88, cw(0, 0, 0));
    wr(8'h84, cw(0, 0, 0));
    wr(8'h80, ctl(0, 1, 0, 0, 0));
    frame();
    send(2'd0, 24'h010000, "R3 half, below half, negative");
    send(2'd0, 24'h030000, "R3 one and a half");
    // R4: offsets after rounding
    wr(8'h80, ctl(0, 1, 5, 5, 5));
    frame();
    send(2'd0, 24'h010000, "R4 offset after round");
    wr(8'h80, ctl(0, 1, -128, 127, -1));
    frame();
    send(2'd0, 24'hC80000, "R4 extreme offsets");

    // R5: saturation high and low
    wr(8'h8C, cw(511, -511, 511));
    wr(8'h88, cw(511, -511, 0));
    wr(8'h84, cw(511, -511, 0));
    wr(8'h80, ctl(0, 1, 127, -128, 0));
    frame();
    send(2'd0, 24'hFFFFFF, "R5 saturate");
    send(2'd0, 24'h000000, "R5 zero input");

    // R6: limited range
    wr(8'h8C, cw(511, 0, 0));
    wr(8'h88, cw(0, 511, 0));
    wr(8'h84, cw(0, 0, 511));
    wr(8'h80, ctl(1, 1, 0, 0, 0));
    frame();
    send(2'd0, 24'h00FFF5, "R6 clamp low and high");
    send(2'd0, 24'hFF0564, "R6 clamp red top");
    send(2'd0, 24'h646464, "R6 mid unchanged");
    drain("R6 drain");

    // R7: channel select codes
    wr(8'h80, ctl(0, 2, 9, 9, 9));
    frame();
    for (int c = 0; c < 4; c++) send(2'(c), 24'h304050, "R7 select code 2");
    wr(8'h80, ctl(0, 3, -9, 9, -9));
    frame();
    for (int c = 0; c < 4; c++) send(2'(c), 24'h304050, "R7 select code 3");
    drain("R7 drain");

    // R11: unknown addresses ignored
    wr(8'h90, 32'hFFFFFFFF);
    wr(8'h81, 32'hFFFFFFFF);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h8D, 32'hFFFFFFFF);
    frame();
    send(2'd2, 24'h304050, "R11 stray writes ignored");
    send(2'd1, 24'h304050, "R11 stray writes ignored b");
    drain("R11 drain");

    // R10: random back-pressure burst
    wr(8'h8C, cw(300, -100, 50));
    wr(8'h88, cw(100, 400, -60));
    wr(8'h84, cw(-20, 80, 450));
    wr(8'h80, ctl(1, 2, 4, -4, 2));
    frame();
    bp_on = 1;
    for (int i = 0; i < 40; i++)
      send(2'($urandom_range(0, 3)), 24'($urandom), "R10 burst order");
    drain("R10 drain");

    finish_run();
  end
endmodule